// File: doc/BRIEF.md
# Bearer Channel Receive Sync Tracker

This block follows the receive synchronisation of one bearer channel in a packet-transfer-mode TC layer. Once per codeword slot, an upstream detector raises a slot strobe and reports whether the sync pattern was seen or missed. From that stream of hits and misses the block maintains a four-state local sync status. The status is hunting, locked, or one of two freewheel states that tolerate a programmable run of consecutive misses before falling back.

Two consecutive-miss limits are held in configuration registers. The exit-true limit (default 7) governs the drop from the optimistic freewheel state to the pessimistic one. The exit-false limit (default 3) governs the drop from the pessimistic freewheel state back to hunting. Each limit is copied into the miss counter at the moment its freewheel state is entered, so a register write never shortens a run already in progress. The block also keeps a one-bit remote receiver status that configuration writes set and the outputs read back.

Top module: `bcs_sync_tracker`

## Requirements
- R1: After reset the local state is Looking (0), synced is 0, remote status is 0, the exit-true limit reads 7 and the exit-false limit reads 3.
- R2: `lock_state` encodes Looking as 0, Freewheel-False as 1, Synced as 2 and Freewheel-True as 3.
- R3: In Looking, a slot with a sync hit moves the state to Synced on the next cycle, and missed slots leave it in Looking.
- R4: In Synced, hit slots keep the state, and a single missed slot moves it to Freewheel-True.
- R5: In Freewheel-True, L consecutive misses move the state to Freewheel-False, and fewer than L misses keep it, where L is the exit-true limit latched on entry (a limit of 0 acts as 1).
- R6: In Freewheel-False, L consecutive misses move the state to Looking, where L is the exit-false limit latched on entry (a limit of 0 acts as 1).
- R7: In either freewheel state, a hit slot returns the state to Synced and restarts the miss count from zero.
- R8: A cycle with `slot_valid` low changes neither the state nor the miss count.
- R9: A limit write made while a freewheel run is in progress does not change the length of that run. It applies from the next entry into the state.
- R10: `synced` is 1 exactly when the state is Synced or Freewheel-True.
- R11: A write with `cfg_sel`=2 stores `cfg_wdata[0]` as remote status (0 out of sync, 1 synced). `remote_ok` shows the stored value on the next cycle, and the write does not affect the local state.
- R12: Writes with `cfg_sel`=0 load the exit-true limit and writes with `cfg_sel`=1 load the exit-false limit. Both read back on the next cycle, and `cfg_sel`=3 writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_valid | input | 1 | One codeword slot evaluated this cycle |
| sync_hit | input | 1 | 1 = sync pattern seen in the slot, 0 = missed |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Write target: 0 exit-true limit, 1 exit-false limit, 2 remote status, 3 none |
| cfg_wdata | input | TH_W | Write data |
| lock_state | output | 2 | Local sync state code |
| synced | output | 1 | Sync believed present |
| remote_ok | output | 1 | Stored remote receiver status |
| th_true_rd | output | TH_W | Exit-true limit readback |
| th_false_rd | output | TH_W | Exit-false limit readback |

## Verification
The bench keeps the default 16-bit limit width and the reset limits of 7 and 3. Directed runs therefore walk the full default fall-back path and the mid-run write case on real register values. The random phase then reprograms both limits to values from 0 to 5 and uses a low hit rate. This makes short runs, zero limits and the complete Looking–Synced–Freewheel cycle occur many hundreds of times within a few thousand cycles.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

  typedef enum logic [1:0] {
    BCS_LOOKING  = 2'd0,
    BCS_FW_FALSE = 2'd1,
    BCS_SYNCED   = 2'd2,
    BCS_FW_TRUE  = 2'd3
  } bcs_state_e;

  localparam int unsigned BCS_NUM_LIMITS = 2;
  localparam logic [1:0]  BCS_SEL_TRUE   = 2'd0;
  localparam logic [1:0]  BCS_SEL_FALSE  = 2'd1;
  localparam logic [1:0]  BCS_SEL_REMOTE = 2'd2;

endpackage

// File: rtl/bcs_cfg_regs.sv
module bcs_cfg_regs #(
  parameter int unsigned TH_W      = 16,
  parameter int unsigned DEF_TRUE  = 7,
  parameter int unsigned DEF_FALSE = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [1:0]      sel,
  input  logic [TH_W-1:0] wdata,
  output logic [TH_W-1:0] lim_true,
  output logic [TH_W-1:0] lim_false,
  output logic            remote_q
);
  import bcs_pkg::*;

  logic [TH_W-1:0] lim_q [BCS_NUM_LIMITS];

  for (genvar gi = 0; gi < BCS_NUM_LIMITS; gi++) begin : g_limit
    localparam logic [TH_W-1:0] RST_VAL = (gi == 0) ? TH_W'(DEF_TRUE) : TH_W'(DEF_FALSE);
    localparam logic [1:0]      MY_SEL  = 2'(gi);
    always_ff @(posedge clk) begin
      if (rst) begin
        lim_q[gi] <= RST_VAL;
      end else if (wr_en && (sel == MY_SEL)) begin
        lim_q[gi] <= wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      remote_q <= 1'b0;
    end else if (wr_en && (sel == BCS_SEL_REMOTE)) begin
      remote_q <= wdata[0];
    end
  end

  assign lim_true  = lim_q[0];
  assign lim_false = lim_q[1];

endmodule

// File: rtl/bcs_miss_counter.sv
module bcs_miss_counter #(
  parameter int unsigned TH_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic            inc,
  input  logic            load,
  input  logic [TH_W-1:0] load_val,
  output logic            last_miss
);
  localparam int unsigned EXT_W = TH_W + 1;

  logic [TH_W-1:0]  cnt_q;
  logic [TH_W-1:0]  lim_q;
  logic [EXT_W-1:0] cnt_next;

  // Count the run so far plus the miss now being judged.
  assign cnt_next  = {1'b0, cnt_q} + EXT_W'(1);
  // A limit of zero compares as reached on the first miss.
  assign last_miss = (cnt_next >= {1'b0, lim_q});

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      lim_q <= '0;
    end else begin
      if (clr) begin
        cnt_q <= '0;
      end else if (inc) begin
        cnt_q <= cnt_next[TH_W-1:0];
      end
      if (load) begin
        lim_q <= load_val;
      end
    end
  end

endmodule

// File: rtl/bcs_state_fsm.sv
module bcs_state_fsm #(
  parameter int unsigned TH_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            slot_valid,
  input  logic            sync_hit,
  input  logic            last_miss,
  input  logic [TH_W-1:0] lim_true,
  input  logic [TH_W-1:0] lim_false,
  output logic [1:0]      state_code,
  output logic            synced_q,
  output logic            cnt_clr,
  output logic            cnt_inc,
  output logic            lim_load,
  output logic [TH_W-1:0] lim_val
);
  import bcs_pkg::*;

  bcs_state_e state_q, state_d;
  logic       miss;
  logic       hit;
  logic       freewheel;

  assign hit       = slot_valid && sync_hit;
  assign miss      = slot_valid && !sync_hit;
  assign freewheel = (state_q == BCS_FW_TRUE) || (state_q == BCS_FW_FALSE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      BCS_LOOKING:  if (hit)  state_d = BCS_SYNCED;
      BCS_SYNCED:   if (miss) state_d = BCS_FW_TRUE;
      BCS_FW_TRUE: begin
        if (hit)                    state_d = BCS_SYNCED;
        else if (miss && last_miss) state_d = BCS_FW_FALSE;
      end
      BCS_FW_FALSE: begin
        if (hit)                    state_d = BCS_SYNCED;
        else if (miss && last_miss) state_d = BCS_LOOKING;
      end
      default: state_d = BCS_LOOKING;
    endcase
  end

  always_comb begin
    cnt_clr  = (state_d != state_q);
    cnt_inc  = freewheel && miss && !last_miss;
    lim_load = (state_d != state_q) &&
               ((state_d == BCS_FW_TRUE) || (state_d == BCS_FW_FALSE));
    lim_val  = (state_d == BCS_FW_TRUE) ? lim_true : lim_false;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= BCS_LOOKING;
      synced_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      synced_q <= (state_d == BCS_SYNCED) || (state_d == BCS_FW_TRUE);
    end
  end

  assign state_code = state_q;

endmodule

// File: rtl/bcs_sync_tracker.sv
module bcs_sync_tracker #(
  parameter int unsigned TH_W      = 16,
  parameter int unsigned DEF_TRUE  = 7,
  parameter int unsigned DEF_FALSE = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            slot_valid,
  input  logic            sync_hit,
  input  logic            cfg_wr_en,
  input  logic [1:0]      cfg_sel,
  input  logic [TH_W-1:0] cfg_wdata,
  output logic [1:0]      lock_state,
  output logic            synced,
  output logic            remote_ok,
  output logic [TH_W-1:0] th_true_rd,
  output logic [TH_W-1:0] th_false_rd
);

  logic [TH_W-1:0] lim_true;
  logic [TH_W-1:0] lim_false;
  logic [TH_W-1:0] lim_val;
  logic            last_miss;
  logic            cnt_clr;
  logic            cnt_inc;
  logic            lim_load;

  bcs_cfg_regs #(
    .TH_W     (TH_W),
    .DEF_TRUE (DEF_TRUE),
    .DEF_FALSE(DEF_FALSE)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (cfg_wr_en),
    .sel      (cfg_sel),
    .wdata    (cfg_wdata),
    .lim_true (lim_true),
    .lim_false(lim_false),
    .remote_q (remote_ok)
  );

  bcs_miss_counter #(.TH_W(TH_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .clr      (cnt_clr),
    .inc      (cnt_inc),
    .load     (lim_load),
    .load_val (lim_val),
    .last_miss(last_miss)
  );

  bcs_state_fsm #(.TH_W(TH_W)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .slot_valid(slot_valid),
    .sync_hit  (sync_hit),
    .last_miss (last_miss),
    .lim_true  (lim_true),
    .lim_false (lim_false),
    .state_code(lock_state),
    .synced_q  (synced),
    .cnt_clr   (cnt_clr),
    .cnt_inc   (cnt_inc),
    .lim_load  (lim_load),
    .lim_val   (lim_val)
  );

  assign th_true_rd  = lim_true;
  assign th_false_rd = lim_false;

endmodule

// File: rtl/bcs_sync_checker.sv
module bcs_sync_checker (
  input logic       clk,
  input logic       rst,
  input logic       slot_valid,
  input logic       sync_hit,
  input logic       cfg_wr_en,
  input logic [1:0] cfg_sel,
  input logic       wbit,
  input logic [1:0] lock_state,
  input logic       synced,
  input logic       remote_ok
);

  assert_look_to_sync_R3: assert property (@(posedge clk) disable iff (rst)
    (lock_state == 2'd0 && slot_valid && sync_hit) |=> (lock_state == 2'd2));

  assert_look_exits_R2: assert property (@(posedge clk) disable iff (rst)
    (lock_state == 2'd0) |=> (lock_state == 2'd0 || lock_state == 2'd2));

  assert_sync_to_fwtrue_R4: assert property (@(posedge clk) disable iff (rst)
    (lock_state == 2'd2 && slot_valid && !sync_hit) |=> (lock_state == 2'd3));

  assert_fw_hit_R7: assert property (@(posedge clk) disable iff (rst)
    (lock_state[0] && slot_valid && sync_hit) |=> (lock_state == 2'd2));

  assert_idle_slot_R8: assert property (@(posedge clk) disable iff (rst)
    (!slot_valid) |=> $stable(lock_state));

  assert_flag_look_R10: assert property (@(posedge clk) disable iff (rst)
    (lock_state == 2'd0 || lock_state == 2'd1) |-> !synced);

  assert_flag_sync_R10: assert property (@(posedge clk) disable iff (rst)
    (lock_state == 2'd2 || lock_state == 2'd3) |-> synced);

  assert_remote_wr_R11: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr_en && cfg_sel == 2'd2) |=> (remote_ok == $past(wbit)));

endmodule

bind bcs_sync_tracker bcs_sync_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .slot_valid(slot_valid),
  .sync_hit  (sync_hit),
  .cfg_wr_en (cfg_wr_en),
  .cfg_sel   (cfg_sel),
  .wbit      (cfg_wdata[0]),
  .lock_state(lock_state),
  .synced    (synced),
  .remote_ok (remote_ok)
);

// File: tb/test_bcs_sync_tracker.sv
`timescale 1ns/1ps
module test_bcs_sync_tracker;

  localparam int TH_W = 16;
  localparam int LOOK = 0, FWF = 1, SYNC = 2, FWT = 3;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            slot_valid = 1'b0;
  logic            sync_hit = 1'b0;
  logic            cfg_wr_en = 1'b0;
  logic [1:0]      cfg_sel = 2'd3;
  logic [TH_W-1:0] cfg_wdata = '0;
  logic [1:0]      lock_state;
  logic            synced;
  logic            remote_ok;
  logic [TH_W-1:0] th_true_rd;
  logic [TH_W-1:0] th_false_rd;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // expected-state model
  int m_state, m_cnt, m_lim, m_true, m_false, m_remote;

  always #2 clk = ~clk;

  bcs_sync_tracker #(.TH_W(TH_W)) i_bcs_sync_tracker (
    .clk(clk), .rst(rst), .slot_valid(slot_valid), .sync_hit(sync_hit),
    .cfg_wr_en(cfg_wr_en), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .lock_state(lock_state), .synced(synced), .remote_ok(remote_ok),
    .th_true_rd(th_true_rd), .th_false_rd(th_false_rd)
  );

  function automatic int exp_synced(int st);
    return (st == SYNC || st == FWT) ? 1 : 0;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_state = LOOK; m_cnt = 0; m_lim = 0;
    m_true = 7; m_false = 3; m_remote = 0;
  endtask

  task automatic model_step(input bit v, input bit h, input bit w,
                            input int s, input int d);
    int nxt;
    nxt = m_state;
    if (v) begin
      case (m_state)
        LOOK: if (h) nxt = SYNC;
        SYNC: if (!h) begin nxt = FWT; m_cnt = 0; m_lim = m_true; end
        default: begin
          if (h) begin
            nxt = SYNC; m_cnt = 0;
          end else if (m_cnt + 1 >= m_lim) begin
            m_cnt = 0;
            if (m_state == FWT) begin nxt = FWF; m_lim = m_false; end
            else nxt = LOOK;
          end else begin
            m_cnt++;
          end
        end
      endcase
    end
    m_state = nxt;
    if (w) begin
      if (s == 0) m_true = d;
      else if (s == 1) m_false = d;
      else if (s == 2) m_remote = d & 1;
    end
  endtask

  task automatic step(input bit v, input bit h, input bit w, input int s,
                      input int d, input string tag);
    @(negedge clk);
    slot_valid = v; sync_hit = h; cfg_wr_en = w;
    cfg_sel = 2'(s); cfg_wdata = TH_W'(d);
    model_step(v, h, w, s, d);
    @(posedge clk);
    #1;
    check({tag, " state"}, int'(lock_state), m_state);
    check("R10 synced", int'(synced), exp_synced(m_state));
    check("R11 remote", int'(remote_ok), m_remote);
    check("R12 true limit", int'(th_true_rd), m_true);
    check("R12 false limit", int'(th_false_rd), m_false);
  endtask

  task automatic misses(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1, 0, 0, 3, 0, tag);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit v, h, w;
    int s, d;
    void'($urandom(32'h5eed_1234));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #0;
    // R1: reset state
    check("R1 state", int'(lock_state), LOOK);
    check("R1 synced", int'(synced), 0);
    check("R1 remote", int'(remote_ok), 0);
    check("R1 true limit", int'(th_true_rd), 7);
    check("R1 false limit", int'(th_false_rd), 3);

    // R3: misses in Looking keep it, a hit locks
    misses(3, "R3");
    check("R3 still looking", int'(lock_state), LOOK);
    step(1, 1, 0, 3, 0, "R3");
    check("R2 synced code", int'(lock_state), 2);
    // R4: hits hold, one miss enters Freewheel-True
    step(1, 1, 0, 3, 0, "R4");
    step(1, 0, 0, 3, 0, "R4");
    check("R2 fw-true code", int'(lock_state), 3);
    // R5: default limit 7 -> 6 more misses stay, the 7th leaves
    misses(6, "R5");
    check("R5 below limit", int'(lock_state), FWT);
    // R8: idle slots leave state and count untouched
    step(0, 0, 0, 3, 0, "R8");
    step(0, 1, 0, 3, 0, "R8");
    check("R8 idle", int'(lock_state), FWT);
    misses(1, "R5");
    check("R5 at limit", int'(lock_state), FWF);
    check("R2 fw-false code", int'(lock_state), 1);
    // R7: a hit in Freewheel-False relocks
    misses(2, "R6");
    step(1, 1, 0, 3, 0, "R7");
    check("R7 relock", int'(lock_state), SYNC);
    // R7: count restarts, so the full 7 are needed again
    misses(1, "R4");
    misses(3, "R7");
    step(1, 1, 0, 3, 0, "R7");
    misses(1, "R4");
    misses(6, "R7");
    check("R7 count restarted", int'(lock_state), FWT);
    // R9: write new limit mid-run, run length unchanged
    step(1, 0, 1, 0, 2, "R9");
    check("R9 mid-run write", int'(lock_state), FWF);
    // R6: three misses return to Looking
    misses(2, "R6");
    check("R6 below limit", int'(lock_state), FWF);
    misses(1, "R6");
    check("R6 at limit", int'(lock_state), LOOK);
    // R9: new exit-true limit 2 applies on the next entry
    step(1, 1, 0, 3, 0, "R9");
    misses(2, "R9");
    check("R9 new limit", int'(lock_state), FWT);
    misses(1, "R9");
    check("R9 new limit used", int'(lock_state), FWF);
    // R11: remote status write, state unaffected
    step(0, 0, 1, 2, 1, "R11");
    check("R11 remote set", int'(remote_ok), 1);
    check("R11 state kept", int'(lock_state), FWF);
    // R12: sel 3 ignored, zero limit acts as one
    step(0, 0, 1, 3, 16'h55, "R12");
    step(0, 0, 1, 1, 0, "R12");
    check("R12 false limit zero", int'(th_false_rd), 0);
    step(1, 1, 0, 3, 0, "R7");
    step(0, 0, 1, 0, 0, "R12");
    misses(1, "R5");
    misses(1, "R5");
    check("R5 zero limit", int'(lock_state), FWF);
    misses(1, "R6");
    check("R6 zero limit", int'(lock_state), LOOK);

    // random phase with small limits
    for (int i = 0; i < 4000; i++) begin
      v = ($urandom % 8) != 0;
      h = ($urandom % 10) < 3;
      w = ($urandom % 16) == 0;
      s = $urandom % 4;
      d = (s == 2) ? ($urandom % 2) : ($urandom % 6);
      step(v, h, w, s, d, "R5 R6 random");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule